// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block produces the two cross-port interrupt lines for a dual-port memory of 1K eight-bit locations. Each port, left and right, has its own active-low enable, active-low write select, active-low output enable and 10-bit address. All of these are sampled on a common clock. The two highest addresses serve as mailboxes. The left port's mailbox is 0x3FE and the right port's mailbox is 0x3FF.

When a port writes into the other port's mailbox, the other port's interrupt line goes low. When the interrupted port reads its own mailbox, its line goes high again. Each port also has a busy input. While a port's busy input is high, any flag update that port's access would cause is discarded. The memory array, the data path and the arbitration that drives the busy inputs all sit outside this block.

Top module: `mbx_irq_top`

## Requirements
- R1: Both `lft_irq_n` and `rgt_irq_n` read 1 (deasserted) after reset, whether reset comes at power-up or in the middle of operation.
- R2: A left write to 0x3FF makes `rgt_irq_n` 0 at the clock edge that samples it. A write means `lft_en_n`=0 and `lft_wr_n`=0.
- R3: A right read of 0x3FF makes `rgt_irq_n` 1 at the clock edge that samples it. A read means `rgt_en_n`=0 and `rgt_oe_n`=0; `rgt_wr_n` is not considered.
- R4: A right write to 0x3FE (`rgt_en_n`=0, `rgt_wr_n`=0) makes `lft_irq_n` 0 at the sampling edge.
- R5: A left read of 0x3FE (`lft_en_n`=0, `lft_oe_n`=0) makes `lft_irq_n` 1 at the sampling edge.
- R6: While `lft_busy`=1, left-port accesses change neither interrupt line.
- R7: While `rgt_busy`=1, right-port accesses change neither interrupt line.
- R8: If one flag is set and cleared in the same cycle, the set wins and the line goes or stays 0.
- R9: The following change neither line: accesses to addresses below 0x3FE, accesses with the enable high, and a write to a port's own mailbox with its output enable high.
- R10: With no qualifying access, both lines hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lft_en_n | input | 1 | Left enable, active low |
| lft_wr_n | input | 1 | Left write select, 0 = write |
| lft_oe_n | input | 1 | Left output enable, active low |
| lft_addr | input | 10 | Left address |
| lft_busy | input | 1 | Left busy, 1 = suppress left updates |
| rgt_en_n | input | 1 | Right enable, active low |
| rgt_wr_n | input | 1 | Right write select, 0 = write |
| rgt_oe_n | input | 1 | Right output enable, active low |
| rgt_addr | input | 10 | Right address |
| rgt_busy | input | 1 | Right busy, 1 = suppress right updates |
| lft_irq_n | output | 1 | Interrupt to the left port, active low |
| rgt_irq_n | output | 1 | Interrupt to the right port, active low |

## Verification
The hardest situation to reach is a set and a clear of the same flag in one cycle. That needs both ports to hit the same mailbox together, one writing it and the other reading it. The stimulus table contains vectors that drive both ports at once for each mailbox. Other vectors pair a busy input with an access that would otherwise set or clear a flag. That shows suppression works separately for each port and for both the set and the clear direction.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;
    // Control strobes of one port as sampled by the flag logic
    typedef struct packed {
        logic en_n;
        logic wr_n;
        logic oe_n;
        logic busy;
    } port_ctl_t;

    // Register state of one interrupt flag
    typedef struct packed {
        logic pending;
    } flag_state_t;
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
    import mbx_irq_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter logic [ADDR_W-1:0] POST_ADDR  = '1,
    parameter logic [ADDR_W-1:0] FETCH_ADDR = '0
) (
    input  port_ctl_t         ctl,
    input  logic [ADDR_W-1:0] addr,
    output logic              post_req,
    output logic              fetch_req
);
    logic wr_hit;
    logic rd_hit;

    always_comb begin
        wr_hit    = !ctl.en_n && !ctl.wr_n && (addr == POST_ADDR);
        rd_hit    = !ctl.en_n && !ctl.oe_n && (addr == FETCH_ADDR);
        post_req  = wr_hit && !ctl.busy;
        fetch_req = rd_hit && !ctl.busy;
    end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag
    import mbx_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic irq_n
);
    flag_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (set_req) begin
            state_d.pending = 1'b1;
        end else if (clr_req) begin
            state_d.pending = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign irq_n = ~state_q.pending;

    // R2 R4 R8
    set_lowers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> (irq_n == 1'b0));
    // R3 R5
    clr_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_req) |=> (irq_n == 1'b1));
    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_req && !clr_req) |=> $stable(irq_n));
endmodule

// File: rtl/mbx_irq_top.sv
module mbx_irq_top
    import mbx_irq_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lft_en_n,
    input  logic              lft_wr_n,
    input  logic              lft_oe_n,
    input  logic [ADDR_W-1:0] lft_addr,
    input  logic              lft_busy,
    input  logic              rgt_en_n,
    input  logic              rgt_wr_n,
    input  logic              rgt_oe_n,
    input  logic [ADDR_W-1:0] rgt_addr,
    input  logic              rgt_busy,
    output logic              lft_irq_n,
    output logic              rgt_irq_n
);
    localparam int NPORT = 2;
    localparam logic [ADDR_W-1:0] RGT_BOX = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] LFT_BOX = {{(ADDR_W-1){1'b1}}, 1'b0};

    port_ctl_t         ctl   [NPORT];
    logic [ADDR_W-1:0] addr  [NPORT];
    logic              post  [NPORT];
    logic              fetch [NPORT];
    logic              irq_n [NPORT];

    assign ctl[0]  = '{en_n: lft_en_n, wr_n: lft_wr_n, oe_n: lft_oe_n, busy: lft_busy};
    assign ctl[1]  = '{en_n: rgt_en_n, wr_n: rgt_wr_n, oe_n: rgt_oe_n, busy: rgt_busy};
    assign addr[0] = lft_addr;
    assign addr[1] = rgt_addr;

    // Port 0 is left, port 1 is right. A port posts into the peer's box
    // and fetches from its own box; its flag is set by the peer's post.
    for (genvar g = 0; g < NPORT; g++) begin : g_port
        localparam logic [ADDR_W-1:0] OWN_BOX  = (g == 0) ? LFT_BOX : RGT_BOX;
        localparam logic [ADDR_W-1:0] PEER_BOX = (g == 0) ? RGT_BOX : LFT_BOX;

        mbx_port_decode #(
            .ADDR_W    (ADDR_W),
            .POST_ADDR (PEER_BOX),
            .FETCH_ADDR(OWN_BOX)
        ) i_dec (
            .ctl      (ctl[g]),
            .addr     (addr[g]),
            .post_req (post[g]),
            .fetch_req(fetch[g])
        );

        mbx_flag i_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_req(post[NPORT-1-g]),
            .clr_req(fetch[g]),
            .irq_n  (irq_n[g])
        );
    end

    assign lft_irq_n = irq_n[0];
    assign rgt_irq_n = irq_n[1];

    // R6
    lft_busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lft_busy && rgt_en_n) |=> ($stable(lft_irq_n) && $stable(rgt_irq_n)));
    // R7
    rgt_busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rgt_busy && lft_en_n) |=> ($stable(lft_irq_n) && $stable(rgt_irq_n)));
    // R9
    plain_addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((lft_addr < LFT_BOX) && (rgt_addr < LFT_BOX)) |=> ($stable(lft_irq_n) && $stable(rgt_irq_n)));
endmodule

// File: tb/test_mbx_irq_top.sv
module test_mbx_irq_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lft_en_n, lft_wr_n, lft_oe_n, lft_busy;
    logic rgt_en_n, rgt_wr_n, rgt_oe_n, rgt_busy;
    logic [9:0] lft_addr, rgt_addr;
    logic lft_irq_n, rgt_irq_n;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mbx_irq_top i_mbx_irq_top (
        .clk(clk), .rst_n(rst_n),
        .lft_en_n(lft_en_n), .lft_wr_n(lft_wr_n), .lft_oe_n(lft_oe_n),
        .lft_addr(lft_addr), .lft_busy(lft_busy),
        .rgt_en_n(rgt_en_n), .rgt_wr_n(rgt_wr_n), .rgt_oe_n(rgt_oe_n),
        .rgt_addr(rgt_addr), .rgt_busy(rgt_busy),
        .lft_irq_n(lft_irq_n), .rgt_irq_n(rgt_irq_n)
    );

    typedef struct packed {
        logic       l_en, l_wr, l_oe;
        logic [9:0] l_a;
        logic       l_b;
        logic       r_en, r_wr, r_oe;
        logic [9:0] r_a;
        logic       r_b;
        logic       exp_l, exp_r;
        logic [3:0] req;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VEC [NVEC] = '{
        '{0,0,1,10'h3FF,0, 1,1,1,10'h000,0, 1,0, 4'd2},  // R2 left posts to right
        '{1,1,1,10'h000,0, 1,1,1,10'h000,0, 1,0, 4'd10}, // R10 hold
        '{1,1,1,10'h000,0, 0,1,0,10'h000,0, 1,0, 4'd9},  // R9 plain read
        '{1,1,1,10'h000,0, 0,1,0,10'h3FF,1, 1,0, 4'd7},  // R7 busy read
        '{1,1,1,10'h000,0, 0,1,0,10'h3FF,0, 1,1, 4'd3},  // R3 right fetch
        '{1,1,1,10'h000,0, 0,0,1,10'h3FE,0, 0,1, 4'd4},  // R4 right posts to left
        '{0,1,0,10'h3FE,1, 1,1,1,10'h000,0, 0,1, 4'd6},  // R6 busy read
        '{0,1,0,10'h3FE,0, 1,1,1,10'h000,0, 1,1, 4'd5},  // R5 left fetch
        '{0,0,1,10'h3FF,1, 1,1,1,10'h000,0, 1,1, 4'd6},  // R6 busy write
        '{1,1,1,10'h000,0, 0,0,1,10'h3FE,1, 1,1, 4'd7},  // R7 busy write
        '{0,0,1,10'h3FD,0, 1,1,1,10'h000,0, 1,1, 4'd9},  // R9 near miss
        '{1,0,1,10'h3FF,0, 1,1,1,10'h000,0, 1,1, 4'd9},  // R9 enable high
        '{0,0,1,10'h3FF,0, 0,1,0,10'h3FF,0, 1,0, 4'd8},  // R8 set beats clear
        '{0,1,0,10'h3FE,0, 0,0,1,10'h3FE,0, 0,0, 4'd8},  // R8 set beats clear
        '{0,1,0,10'h3FE,0, 0,1,0,10'h3FF,0, 1,1, 4'd3},  // R3 R5 both fetch
        '{0,0,1,10'h3FE,0, 1,1,1,10'h000,0, 1,1, 4'd9}   // R9 own box write
    };

    task automatic idle();
        lft_en_n = 1; lft_wr_n = 1; lft_oe_n = 1; lft_addr = '0; lft_busy = 0;
        rgt_en_n = 1; rgt_wr_n = 1; rgt_oe_n = 1; rgt_addr = '0; rgt_busy = 0;
    endtask

    task automatic check(input string req, input logic el, input logic er);
        checks++;
        if (lft_irq_n !== el || rgt_irq_n !== er) begin
            errors++;
            $display("FAIL %s: lft_irq_n=%b rgt_irq_n=%b expected %b %b",
                     req, lft_irq_n, rgt_irq_n, el, er);
        end
    endtask

    initial begin
        idle();
        #25;
        check("R1", 1'b1, 1'b1);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #5;
        check("R1", 1'b1, 1'b1);
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            {lft_en_n, lft_wr_n, lft_oe_n, lft_addr, lft_busy} =
                {VEC[i].l_en, VEC[i].l_wr, VEC[i].l_oe, VEC[i].l_a, VEC[i].l_b};
            {rgt_en_n, rgt_wr_n, rgt_oe_n, rgt_addr, rgt_busy} =
                {VEC[i].r_en, VEC[i].r_wr, VEC[i].r_oe, VEC[i].r_a, VEC[i].r_b};
            @(posedge clk); #5;
            check($sformatf("R%0d", VEC[i].req), VEC[i].exp_l, VEC[i].exp_r);
        end
        // R1: reset in the middle of operation with both flags pending
        @(negedge clk);
        idle();
        lft_en_n = 0; lft_wr_n = 0; lft_addr = 10'h3FF;
        rgt_en_n = 0; rgt_wr_n = 0; rgt_addr = 10'h3FE;
        @(posedge clk); #5;
        check("R2", 1'b0, 1'b0);
        @(negedge clk); idle(); rst_n = 1'b0;
        #2;
        check("R1", 1'b1, 1'b1);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #5;
        check("R10", 1'b1, 1'b1);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: run did not complete, expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule